// File: doc/BRIEF.md
# PLL Bring-Up Supervisor with Bounded Retry

This block brings a PLL out of reset and confirms that it has locked. A pulse on `start` begins one bring-up attempt. The attempt first drives the PLL reset. With reset still held it strobes the configuration words out one index per cycle. It then raises enable alongside reset for one cycle and releases reset. After that it waits a settle interval counted in reference clock cycles. At the end of the interval it samples a lock indicator. The lock indicator is passed through a two-flop synchronizer first, and a high level means locked.

A good sample raises `done` and clears the count of consecutive failures. A missed lock gives a one-cycle `failed` pulse and adds one to that count, after which the block retries. In system mode every retry repeats the whole sequence, including the configuration load, and uses the short settle interval. In fixed mode the configuration is loaded only once and the long interval is used. If lock is already present at the first sample, the retry loop is never entered. Otherwise each retry holds reset, with enable high, for one long interval and then releases it for a second long interval before sampling again. When the count reaches the failure limit, the block raises a system-reset request and stays parked until its own reset.

States: IDLE, RST_ON (reset asserted), LOAD (configuration strobes), ARM (enable and reset together), SETTLE (reset released, waiting), SAMPLE (lock examined), HOLD (fixed-mode reset pulse), LOCKED, HALT. Transitions: IDLE→RST_ON on start; RST_ON→LOAD; LOAD→ARM after the last word; ARM→SETTLE; SETTLE→SAMPLE when the interval ends; SAMPLE→LOCKED on lock; SAMPLE→HALT on a miss that reaches the limit; SAMPLE→RST_ON on any other miss in system mode; SAMPLE→HOLD on any other miss in fixed mode; HOLD→SETTLE when the interval ends; LOCKED→RST_ON on start; HALT stays in HALT.

Top module: `pll_bringup_sup`

## Requirements
- R1: While and after reset, with no start seen, pll_rst, pll_en, cfg_load, done, failed and sys_rst_req are all 0 and cfg_sel is 0.
- R2: A start pulse taken in IDLE or LOCKED begins an attempt. pll_rst is high for one cycle. Then cfg_load is high for CFG_WORDS cycles with pll_rst high, and cfg_sel counts 0 up to CFG_WORDS-1. Then pll_rst and pll_en are both high for one cycle. Then pll_rst drops while pll_en stays high.
- R3: After reset is released, the window with pll_en high and pll_rst low before lock is sampled lasts the settle count plus the one sample cycle. The settle count is SETTLE_SHORT cycles in system mode (fixed_mode=0) and SETTLE_LONG cycles in fixed mode (fixed_mode=1). The mode is captured when start is taken.
- R4: Lock is taken from pll_lock_raw through a two-flop synchronizer, and 1 means locked. A lock at the sample point raises done and holds done high, with pll_en high and pll_rst low, until the next accepted start.
- R5: A miss at the sample point gives a one-cycle failed pulse and adds one to the consecutive-failure count. Below the limit, system mode then repeats the full sequence from R2, configuration load included.
- R6: Below the limit, a fixed-mode miss loads no configuration again. Instead pll_rst and pll_en are held high for SETTLE_LONG cycles, followed by a released window of SETTLE_LONG cycles before the next sample.
- R7: In fixed mode, a lock present at the first sample finishes the run with exactly one reset pulse and no HOLD phase.
- R8: A successful lock clears the consecutive-failure count to 0, so a later run again tolerates FAIL_LIMIT-1 misses before locking.
- R9: The miss that brings the count to FAIL_LIMIT raises sys_rst_req. After that, sys_rst_req stays high, pll_en, cfg_load and done stay low, and start has no effect until rst_n is asserted.
- R10: A start pulse that arrives while an attempt is in progress is ignored.
- R11: The consecutive-failure count never exceeds FAIL_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (taken in IDLE or LOCKED) |
| fixed_mode | input | 1 | 1 selects the long settle interval and reset-pulse retry; 0 selects the short interval and full-sequence retry |
| pll_lock_raw | input | 1 | Asynchronous lock indicator from the PLL, high when locked |
| pll_rst | output | 1 | PLL reset |
| pll_en | output | 1 | PLL enable |
| cfg_load | output | 1 | Configuration word load strobe |
| cfg_sel | output | IDX_W (2) | Index of the configuration word being loaded |
| done | output | 1 | PLL locked, run finished |
| failed | output | 1 | One-cycle pulse per missed lock sample |
| sys_rst_req | output | 1 | System reset request after FAIL_LIMIT consecutive misses |

## Verification
The main function is tried with a lock stub that withholds lock for a chosen number of attempts, counted by reset pulses, in both modes. Zero misses separates the immediate-lock path, and in fixed mode this is the skip of the retry loop. One or two misses separates full-sequence retry from reset-pulse retry, because the two give different counts of configuration strobes, reset-with-enable cycles and released cycles. Runs with misses at or beyond the limit separate escalation from retry. Directed runs chain two runs of two misses each without a reset in between, which only completes if success clears the count. They also give a second start during an attempt and a start while parked.

// File: rtl/pllsup_pkg.sv
package pllsup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_LOAD,
        ST_ARM,
        ST_SETTLE,
        ST_SAMPLE,
        ST_HOLD,
        ST_LOCKED,
        ST_HALT
    } sup_state_e;

endpackage

// File: rtl/pllsup_sync2.sv
module pllsup_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/pllsup_phase_timer.sv
module pllsup_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] elapsed
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != {W{1'b1}}) begin
            elapsed <= elapsed + W'(1);
        end
    end

endmodule

// File: rtl/pllsup_fail_counter.sv
module pllsup_fail_counter #(
    parameter int LIMIT = 3,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          last
);

    assign last = (count == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CW'(LIMIT))) begin
            count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/pll_bringup_sup.sv
module pll_bringup_sup
    import pllsup_pkg::*;
#(
    parameter int CFG_WORDS    = 4,
    parameter int SETTLE_SHORT = 20,
    parameter int SETTLE_LONG  = 80,
    parameter int FAIL_LIMIT   = 3,
    localparam int IDX_W   = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
    localparam int MAX_A   = (SETTLE_SHORT > CFG_WORDS) ? SETTLE_SHORT : CFG_WORDS,
    localparam int MAX_LEN = (SETTLE_LONG > MAX_A) ? SETTLE_LONG : MAX_A,
    localparam int TIMER_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W   = $clog2(FAIL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fixed_mode,
    input  logic             pll_lock_raw,
    output logic             pll_rst,
    output logic             pll_en,
    output logic             cfg_load,
    output logic [IDX_W-1:0] cfg_sel,
    output logic             done,
    output logic             failed,
    output logic             sys_rst_req
);

    sup_state_e state_q, state_d;
    logic               mode_q;
    logic               lock_s;
    logic [TIMER_W-1:0] elapsed;
    logic [CNT_W-1:0]   fail_cnt;
    logic               fail_last;
    logic               take_start;
    logic               settle_end;

    pllsup_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pll_lock_raw),
        .sync_out (lock_s)
    );

    pllsup_phase_timer #(.W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .elapsed (elapsed)
    );

    pllsup_fail_counter #(.LIMIT(FAIL_LIMIT)) u_fails (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q == ST_SAMPLE) && lock_s),
        .inc   ((state_q == ST_SAMPLE) && !lock_s),
        .count (fail_cnt),
        .last  (fail_last)
    );

    assign take_start = start && ((state_q == ST_IDLE) || (state_q == ST_LOCKED));
    assign settle_end = mode_q ? (elapsed == TIMER_W'(SETTLE_LONG - 1))
                               : (elapsed == TIMER_W'(SETTLE_SHORT - 1));

    // state register and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                mode_q <= fixed_mode;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RST_ON;
            ST_RST_ON: state_d = ST_LOAD;
            ST_LOAD:   if (elapsed == TIMER_W'(CFG_WORDS - 1)) state_d = ST_ARM;
            ST_ARM:    state_d = ST_SETTLE;
            ST_SETTLE: if (settle_end) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (lock_s)         state_d = ST_LOCKED;
                else if (fail_last) state_d = ST_HALT;
                else if (mode_q)    state_d = ST_HOLD;
                else                state_d = ST_RST_ON;
            end
            ST_HOLD:   if (elapsed == TIMER_W'(SETTLE_LONG - 1)) state_d = ST_SETTLE;
            ST_LOCKED: if (start) state_d = ST_RST_ON;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        pll_rst     = 1'b0;
        pll_en      = 1'b0;
        cfg_load    = 1'b0;
        cfg_sel     = '0;
        done        = 1'b0;
        failed      = 1'b0;
        sys_rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RST_ON: pll_rst = 1'b1;
            ST_LOAD: begin
                pll_rst  = 1'b1;
                cfg_load = 1'b1;
                cfg_sel  = elapsed[IDX_W-1:0];
            end
            ST_ARM: begin
                pll_rst = 1'b1;
                pll_en  = 1'b1;
            end
            ST_SETTLE: pll_en = 1'b1;
            ST_SAMPLE: begin
                pll_en = 1'b1;
                failed = !lock_s;
            end
            ST_HOLD: begin
                pll_rst = 1'b1;
                pll_en  = 1'b1;
            end
            ST_LOCKED: begin
                pll_en = 1'b1;
                done   = 1'b1;
            end
            ST_HALT:   sys_rst_req = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pll_bringup_sup_chk.sv
module pll_bringup_sup_chk #(
    parameter int SETTLE_SHORT = 20,
    parameter int SETTLE_LONG  = 80,
    parameter int FAIL_LIMIT   = 3,
    parameter int CNT_W        = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             pll_rst,
    input logic             pll_en,
    input logic             cfg_load,
    input logic             done,
    input logic             failed,
    input logic             sys_rst_req,
    input logic [CNT_W-1:0] fail_cnt
);

    int unsigned win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= 0;
        end else if (pll_en && !pll_rst && !done) begin
            win_cnt <= win_cnt + 1;
        end else begin
            win_cnt <= 0;
        end
    end

    // R2: configuration words are only loaded under reset
    p_cfg_under_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (pll_rst && !pll_en));

    // R3: a miss is reported only after a full settle interval
    p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> ((win_cnt == SETTLE_SHORT) || (win_cnt == SETTLE_LONG)));

    // R4: done means the PLL runs enabled out of reset
    p_done_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pll_en && !pll_rst));

    // R4: done holds until a new start
    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5: failure indication is a single-cycle pulse
    p_fail_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        failed |=> !failed);

    // R8: reaching lock leaves the failure count at zero
    p_clear_on_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (fail_cnt == '0));

    // R9: the system reset request is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> sys_rst_req);

    // R9: nothing else is driven while parked
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (!pll_en && !cfg_load && !done && !failed));

    // R11: failure count stays within the limit
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt <= CNT_W'(FAIL_LIMIT));

endmodule

bind pll_bringup_sup pll_bringup_sup_chk #(
    .SETTLE_SHORT (SETTLE_SHORT),
    .SETTLE_LONG  (SETTLE_LONG),
    .FAIL_LIMIT   (FAIL_LIMIT),
    .CNT_W        (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pll_rst     (pll_rst),
    .pll_en      (pll_en),
    .cfg_load    (cfg_load),
    .done        (done),
    .failed      (failed),
    .sys_rst_req (sys_rst_req),
    .fail_cnt    (fail_cnt)
);

// File: tb/pll_bringup_sup_test.sv
module pll_bringup_sup_test;

    localparam int W = 4;

    typedef struct packed {
        logic fx;
        int   fails;
        int   e_done;
        int   e_sys;
        int   e_fail;
        int   e_rst;
        int   e_cfg;
        int   e_win;
        int   e_hold;
    } vec_t;

    // short=20 long=80 words=4 limit=3
    localparam vec_t VEC [7] = '{
        '{1'b0, 0, 1, 0, 0, 1, 4,  21,   1},
        '{1'b0, 1, 1, 0, 1, 2, 8,  42,   2},
        '{1'b0, 2, 1, 0, 2, 3, 12, 63,   3},
        '{1'b0, 4, 0, 1, 3, 3, 12, 63,   3},
        '{1'b1, 0, 1, 0, 0, 1, 4,  81,   1},
        '{1'b1, 2, 1, 0, 2, 3, 4,  243, 161},
        '{1'b1, 5, 0, 1, 3, 3, 4,  243, 161}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fixed_mode = 1'b0;
    logic pll_lock_raw = 1'b0;
    logic pll_rst, pll_en, cfg_load, done, failed, sys_rst_req;
    logic [1:0] cfg_sel;

    int checks = 0;
    int errors = 0;
    int fails_cfg = 0;
    int att = 0, rel = 0;
    int n_rst = 0, n_cfg = 0, n_bad = 0, n_fail = 0, n_win = 0, n_hold = 0;
    logic prev_rst = 1'b0;
    int cycles = 0;

    always #2 clk = ~clk;

    pll_bringup_sup uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fixed_mode   (fixed_mode),
        .pll_lock_raw (pll_lock_raw),
        .pll_rst      (pll_rst),
        .pll_en       (pll_en),
        .cfg_load     (cfg_load),
        .cfg_sel      (cfg_sel),
        .done         (done),
        .failed       (failed),
        .sys_rst_req  (sys_rst_req)
    );

    // lock stub and output monitor
    always @(negedge clk) begin
        if (pll_rst && !prev_rst) begin
            n_rst = n_rst + 1;
            att   = att + 1;
        end
        prev_rst = pll_rst;
        if (pll_rst) rel = 0;
        else if (pll_en) rel = rel + 1;
        pll_lock_raw = !pll_rst && pll_en && (rel >= 5) && (att > fails_cfg);
        if (cfg_load) begin
            if (cfg_sel != 2'(n_cfg % W)) n_bad = n_bad + 1;
            n_cfg = n_cfg + 1;
        end
        if (failed) n_fail = n_fail + 1;
        if (pll_en && !pll_rst && !done && !sys_rst_req) n_win = n_win + 1;
        if (pll_en && pll_rst) n_hold = n_hold + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        att = 0; rel = 0; n_rst = 0; n_cfg = 0; n_bad = 0;
        n_fail = 0; n_win = 0; n_hold = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run(input logic fx, input int f);
        @(posedge clk); #1;
        fixed_mode = fx;
        fails_cfg  = f;
        clear_mon();
        pulse_start();
        for (int t = 0; t < 5000 && !(done || sys_rst_req); t++) begin
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check(!pll_rst && !pll_en && !cfg_load && !done && !failed && !sys_rst_req && cfg_sel == 0,
              "R1 outputs in reset", {pll_rst, pll_en, cfg_load, done, failed, sys_rst_req}, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(!pll_rst && !pll_en && !cfg_load && !done && !failed && !sys_rst_req,
              "R1 outputs idle after reset", {pll_rst, pll_en, cfg_load, done, failed, sys_rst_req}, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        foreach (VEC[i]) begin
            do_reset();
            run(VEC[i].fx, VEC[i].fails);
            check(int'(done) == VEC[i].e_done, "R4 done", int'(done), VEC[i].e_done);
            check(int'(sys_rst_req) == VEC[i].e_sys, "R9 sys_rst_req", int'(sys_rst_req), VEC[i].e_sys);
            check(n_fail == VEC[i].e_fail, "R5 failed pulses", n_fail, VEC[i].e_fail);
            check(n_rst == VEC[i].e_rst, "R7 reset pulses", n_rst, VEC[i].e_rst);
            check(n_cfg == VEC[i].e_cfg, "R2 cfg strobes", n_cfg, VEC[i].e_cfg);
            check(n_bad == 0, "R2 cfg_sel order", n_bad, 0);
            check(n_win == VEC[i].e_win, "R3 released cycles", n_win, VEC[i].e_win);
            check(n_hold == VEC[i].e_hold, "R6 reset-with-enable cycles", n_hold, VEC[i].e_hold);
        end

        // R8: two runs of two misses without reset in between
        do_reset();
        run(1'b0, 2);
        check(done == 1'b1, "R8 first run done", int'(done), 1);
        run(1'b0, 2);
        check(done == 1'b1, "R8 second run done", int'(done), 1);
        check(sys_rst_req == 1'b0, "R8 no escalation", int'(sys_rst_req), 0);
        check(n_fail == 2, "R8 second run misses", n_fail, 2);

        // R10: start during an attempt is ignored
        do_reset();
        @(posedge clk); #1;
        fixed_mode = 1'b0; fails_cfg = 0; clear_mon();
        pulse_start();
        repeat (10) @(posedge clk);
        #1;
        pulse_start();
        repeat (60) @(posedge clk);
        #1;
        check(n_rst == 1, "R10 reset pulses", n_rst, 1);
        check(n_cfg == 4, "R10 cfg strobes", n_cfg, 4);
        check(done == 1'b1, "R10 done", int'(done), 1);

        // R9: parked state ignores start
        do_reset();
        run(1'b0, 9);
        check(sys_rst_req == 1'b1, "R9 escalated", int'(sys_rst_req), 1);
        clear_mon();
        pulse_start();
        repeat (200) @(posedge clk);
        #1;
        check(sys_rst_req == 1'b1, "R9 request held", int'(sys_rst_req), 1);
        check(n_rst == 0, "R9 no reset pulse after start", n_rst, 0);
        check(n_cfg == 0, "R9 no cfg strobe after start", n_cfg, 0);
        check(!pll_en && !done, "R9 enable and done low", {pll_en, done}, 0);

        // R1: reset leaves the parked state
        do_reset();
        #1;
        check(!sys_rst_req && !pll_en && !done, "R1 reset clears park",
              {sys_rst_req, pll_en, done}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule